// File: doc/BRIEF.md
# Split-Chain Array Multiplier

This block multiplies two unsigned N-bit integers and returns the full 2N-bit product. It builds one partial product per bit of the second operand: that bit ANDed with the first operand, shifted left by the bit index. The partial products are then reduced by two carry-save chains that work side by side. One chain takes the even-indexed partial products and the other takes the odd-indexed ones. Each row in a chain is a 3:2 compressor that folds one more partial product into a running sum/carry pair. Because successive rows in a chain are two positions apart in the overall partial-product order, each chain is only about half as deep as a single chain would be.

When both chains are done, the four vectors they leave are merged by one 4:2 compressor stage. A 2N-bit carry-propagate adder then resolves the remaining pair into the product. Carries move up one bit between rows, and any bit above position 2N-1 is dropped; no true product needs it. A parameter selects whether the product leaves through an output register with synchronous active-high reset, or straight from the adder.

Top module: `dmul_top`

## Requirements
- R1: `prod` equals the unsigned product `a * b` as a 2N-bit value for every pair of operands.
- R2: With `REG_OUT` = 1, `prod` takes the product of the operands sampled at a rising edge of `clk` just after that edge, and holds its value between edges regardless of operand changes.
- R3: With `REG_OUT` = 0, `prod` follows the operands combinationally, with no clock edge in between.
- R4: With `REG_OUT` = 1, `rst` high at a rising edge sets `prod` to zero, whatever the operands are.
- R5: When either operand is zero, the product is zero.
- R6: When either operand is one, the product equals the other operand.
- R7: All-ones times all-ones gives 2^(2N) - 2^(N+1) + 1, with the top product bit set; the product never exceeds this value.
- R8: An odd operand width, where the even chain holds one more partial product than the odd chain, still gives exact products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned; bit i selects partial product i |
| prod | output | 2N | Unsigned product |

## Verification
The bench runs every operand pair through a 6-bit registered instance. Before each edge it checks that the old product is still held, and after the edge it checks the new one; this is how a missing or doubled register stage is told apart from a right result. A 5-bit combinational instance is also run through every pair. Its chains have unequal lengths, which exposes an indexing error in the odd/even split that an even width can hide. Zero, one and all-ones operands are counted on their own: they isolate, in turn, stray carries, the placement of a single partial product, and the carries that reach the top product bit.

// File: rtl/dmul_pkg.sv
package dmul_pkg;
  // Number of partial products that land in the chain of the given parity.
  function automatic int chain_len(input int n, input int parity);
    return (n - parity + 1) / 2;
  endfunction
endpackage

// File: rtl/dmul_ppgen.sv
module dmul_ppgen #(
  parameter int N = 16,
  localparam int W2 = 2 * N
) (
  input  logic [N-1:0]          a,
  input  logic [N-1:0]          b,
  output logic [N-1:0][W2-1:0]  pp
);
  for (genvar i = 0; i < N; i++) begin : g_row
    assign pp[i] = W2'(a & {N{b[i]}}) << i;
  end
endmodule

// File: rtl/dmul_csa_chain.sv
module dmul_csa_chain #(
  parameter int W2 = 32,
  parameter int K  = 8,
  localparam int ROWS = (K > 2) ? K - 2 : 0
) (
  input  logic [K-1:0][W2-1:0] pp,
  output logic [W2-1:0]        sum,
  output logic [W2-1:0]        carry
);
  logic [W2-1:0] s_v [ROWS+1];
  logic [W2-1:0] c_v [ROWS+1];

  // Seed the running pair with the first one or two partial products.
  if (K == 1) begin : g_seed1
    assign s_v[0] = pp[0];
    assign c_v[0] = '0;
  end else begin : g_seed2
    assign s_v[0] = pp[0];
    assign c_v[0] = pp[1];
  end

  // Each row folds one more partial product of this chain in.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign s_v[r+1] = s_v[r] ^ c_v[r] ^ pp[r+2];
    assign c_v[r+1] = ((s_v[r] & c_v[r]) | (s_v[r] & pp[r+2]) |
                       (c_v[r] & pp[r+2])) << 1;
  end

  assign sum   = s_v[ROWS];
  assign carry = c_v[ROWS];
endmodule

// File: rtl/dmul_comp42.sv
module dmul_comp42 #(
  parameter int W = 32
) (
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  input  logic [W-1:0] x3,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  logic [W-1:0] t;
  logic [W-1:0] ci;

  assign t     = x0 ^ x1 ^ x2;
  assign ci[0] = 1'b0;
  assign carry[0] = 1'b0;

  for (genvar i = 1; i < W; i++) begin : g_bit
    // lateral carry from the first 3:2 of the bit below
    assign ci[i]    = (x0[i-1] & x1[i-1]) | (x0[i-1] & x2[i-1]) | (x1[i-1] & x2[i-1]);
    // output carry of the second 3:2 of the bit below
    assign carry[i] = (t[i-1] & x3[i-1]) | (t[i-1] & ci[i-1]) | (x3[i-1] & ci[i-1]);
  end

  assign sum = t ^ x3 ^ ci;
endmodule

// File: rtl/dmul_top.sv
module dmul_top #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int W2 = 2 * N,
  localparam int KE = dmul_pkg::chain_len(N, 0),
  localparam int KO = dmul_pkg::chain_len(N, 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  a,
  input  logic [N-1:0]  b,
  output logic [W2-1:0] prod
);
  logic [N-1:0][W2-1:0]  pp;
  logic [KE-1:0][W2-1:0] pp_even;
  logic [KO-1:0][W2-1:0] pp_odd;
  logic [W2-1:0] se, ce, so, co, s42, c42, p_comb;

  dmul_ppgen #(.N(N)) u_pp (.a(a), .b(b), .pp(pp));

  for (genvar j = 0; j < KE; j++) begin : g_even
    assign pp_even[j] = pp[2*j];
  end
  for (genvar j = 0; j < KO; j++) begin : g_odd
    assign pp_odd[j] = pp[2*j+1];
  end

  dmul_csa_chain #(.W2(W2), .K(KE)) u_even (.pp(pp_even), .sum(se), .carry(ce));
  dmul_csa_chain #(.W2(W2), .K(KO)) u_odd  (.pp(pp_odd),  .sum(so), .carry(co));

  dmul_comp42 #(.W(W2)) u_merge (
    .x0(se), .x1(ce), .x2(so), .x3(co), .sum(s42), .carry(c42)
  );

  assign p_comb = s42 + c42;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) prod <= '0;
      else     prod <= p_comb;
    end
  end else begin : g_comb
    assign prod = p_comb;
  end
endmodule

// File: rtl/dmul_chk.sv
module dmul_chk #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int W2 = 2 * N
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  a,
  input logic [N-1:0]  b,
  input logic [W2-1:0] prod
);
  logic [N-1:0] ea, eb;
  logic         armed;
  localparam logic [W2-1:0] PMAX = W2'({N{1'b1}}) * W2'({N{1'b1}});

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      ea    <= a;
      eb    <= b;
      armed <= rst ? 1'b0 : 1'b1;
    end
    // R4
    reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> prod == '0);
  end else begin : g_comb
    assign ea    = a;
    assign eb    = b;
    assign armed = 1'b1;
  end

  // R1, R2, R3
  prod_value_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> prod == W2'(ea) * W2'(eb));
  // R5
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && (ea == '0 || eb == '0)) |-> prod == '0);
  // R6
  unit_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && eb == N'(1)) |-> prod == W2'(ea));
  // R7
  prod_bound_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> prod <= PMAX);
endmodule

bind dmul_top dmul_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .prod(prod)
);

// File: tb/sim_dmul_top.sv
module sim_dmul_top;
  localparam int CLK_P = 10;
  localparam int NA = 6;
  localparam int NB = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NA-1:0]   a0 = '0, b0 = '0;
  logic [2*NA-1:0] prod0;
  logic [NB-1:0]   a1 = '0, b1 = '0;
  logic [2*NB-1:0] prod1;
  int vecs = 0;
  int miss = 0;

  always #(CLK_P/2) clk = ~clk;

  dmul_top #(.N(NA), .REG_OUT(1'b1)) u0 (.clk(clk), .rst(rst), .a(a0), .b(b0), .prod(prod0));
  dmul_top #(.N(NB), .REG_OUT(1'b0)) u1 (.clk(clk), .rst(rst), .a(a1), .b(b1), .prod(prod1));

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    miss++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    int prev;
    // R4: reset clears the registered product even with nonzero operands
    @(negedge clk); a0 = 6'd5; b0 = 6'd7;
    @(posedge clk); #1; chk("R4", int'(prod0), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1; chk("R2", int'(prod0), 35);
    prev = 35;

    // Exhaustive registered sweep: R1, R2, R5, R6, R7
    for (int x = 0; x < (1 << NA); x++) begin
      for (int y = 0; y < (1 << NA); y++) begin
        string tag;
        @(negedge clk); a0 = NA'(x); b0 = NA'(y);
        #1; chk("R2", int'(prod0), prev);
        if (x == 0 || y == 0) tag = "R5";
        else if (x == 1 || y == 1) tag = "R6";
        else if (x == 63 && y == 63) tag = "R7";
        else tag = "R1";
        @(posedge clk); #1; chk(tag, int'(prod0), x * y);
        prev = x * y;
      end
    end
    // R7: all-ones square has its top bit set
    chk("R7", int'(prod0[2*NA-1]), 1);

    // R4: reset mid-run with all-ones operands
    @(negedge clk); a0 = '1; b0 = '1; rst = 1'b1;
    @(posedge clk); #1; chk("R4", int'(prod0), 0);
    @(negedge clk); rst = 1'b0;

    // Exhaustive combinational sweep at odd width: R3, R8
    for (int x = 0; x < (1 << NB); x++) begin
      for (int y = 0; y < (1 << NB); y++) begin
        @(negedge clk); a1 = NB'(x); b1 = NB'(y);
        #1; chk((x == 31 && y == 31) ? "R7" : "R8", int'(prod1), x * y);
      end
    end
    // R3: product follows operands with no clock edge
    @(posedge clk); #2; a1 = 5'd13; b1 = 5'd11;
    #1; chk("R3", int'(prod1), 143);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule